// File: doc/BRIEF.md
# Virtual Function Capability Register Block

This block holds the extended-capability registers one physical function uses to expose and control its virtual functions. Configuration software reaches it through a simple dword-indexed read/write port. Some fields are read-only and describe the function. They give the initial and maximum virtual function counts, the routing-ID offset and spacing of the first and following virtual functions, and the supported page sizes. The other fields are writable controls: enable, migration enable, a routing-interpretation (ARI) mode bit, virtual function memory enable, the requested virtual function count and the selected system page size.

The block rejects illegal writes by keeping the old value. The allowed virtual function count depends on whether migration is active. A page size is accepted only if it is a single advertised size. A conventional reset returns every writable field to its default. A function-level reset stops the virtual functions but keeps the count, the ARI mode and the page setting. The routing-offset and stride pair is looked up from the present count and ARI mode and is registered. Downstream logic receives the effective count, the enable, the gated memory enable and the chosen page size.

Top module: `svf_cap_regs`

## Requirements
- R1: Reads return fixed identity words: index 0 gives {next pointer[31:20], version[19:16], capability ID[15:0]}, index 1 gives migration capability in bit 0, index 3 gives {maximum count[31:16], initial count[15:0]}, and index 6 gives the supported page mask.
- R2: The control word at index 2 holds enable in bit 0, migration enable in bit 1, ARI mode in bit 2 and memory enable in bit 3. Writes set these bits, except that migration enable stays 0 when the function is not migration capable.
- R3: A count write at index 4 (bits 15:0) is accepted only when the value is from 1 up to the maximum count while migration enable is set, or from 1 up to the initial count while it is clear. Any other value leaves the stored count unchanged.
- R4: A count write while enable is 1 is ignored.
- R5: A page-size write at index 7 is accepted only if exactly one bit is set and that bit is in the supported mask. Otherwise the old value is kept. The reset default is the lowest set bit of the mask.
- R6: Writes to indices 0, 1, 3, 5 and 6 have no effect, and reads of indices 8 to 15 return zero.
- R7: Index 5 reads {stride[31:16], first offset[15:0]}. With ARI mode set, offset is 1 and stride 1. Otherwise stride is 2 and offset is 4, or 12 when the count exceeds 8. The pair follows a count or mode change one clock later.
- R8: vf_en_o is the enable bit. vf_count_o is the stored count while enabled and 0 otherwise. vf_mem_en_o is the memory enable bit ANDed with enable. page_size_o is the stored page size.
- R9: Conventional reset clears the control word and the count, sets the page size to its default, and sets the offset/stride pair to the value for a count of 0 with ARI clear.
- R10: A function-level reset pulse clears enable, migration enable and memory enable. It keeps the count, the ARI mode and the page size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Conventional reset, active low, asynchronous |
| flr | input | 1 | Function-level reset pulse |
| cfg_wr | input | 1 | Write strobe for the configuration port |
| cfg_addr | input | 4 | Dword index for both reads and writes |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_addr, combinational |
| vf_en_o | output | 1 | Virtual functions enabled |
| vf_mem_en_o | output | 1 | Virtual function memory space enabled |
| vf_count_o | output | 16 | Effective virtual function count |
| page_size_o | output | 32 | Selected system page size, one-hot |

## Verification
The most likely internal faults are a rejected write that still updates a field, or a legal write that is dropped. Either fault shows at the next read of that index and, for the count and the page, on vf_count_o or page_size_o on the cycle after the write edge. A wrong limit choice between the initial and maximum counts shows only at the boundary values when migration changes state, so those values are driven directly. A fault in the lookup or its register shows at index 5 either in the cycle right after a count change or one cycle later, and the bench checks both cycles.

// File: rtl/svf_pkg.sv
package svf_pkg;

  localparam int unsigned ADDR_W = 4;
  localparam int unsigned CNT_W  = 16;

  localparam logic [ADDR_W-1:0] IDX_HDR   = 4'h0;
  localparam logic [ADDR_W-1:0] IDX_CAP   = 4'h1;
  localparam logic [ADDR_W-1:0] IDX_CTL   = 4'h2;
  localparam logic [ADDR_W-1:0] IDX_VFCNT = 4'h3;
  localparam logic [ADDR_W-1:0] IDX_NUMVF = 4'h4;
  localparam logic [ADDR_W-1:0] IDX_RID   = 4'h5;
  localparam logic [ADDR_W-1:0] IDX_PGSUP = 4'h6;
  localparam logic [ADDR_W-1:0] IDX_PGSEL = 4'h7;

  typedef struct packed {
    logic mse;
    logic ari;
    logic mig;
    logic en;
  } ctl_t;

  function automatic logic count_legal(input logic [CNT_W-1:0] v, input logic mig_act,
                                       input logic [CNT_W-1:0] initv, input logic [CNT_W-1:0] totv);
    logic [CNT_W-1:0] lim;
    lim = mig_act ? totv : initv;
    return (v != '0) && (v <= lim);
  endfunction

  function automatic logic page_legal(input logic [31:0] v, input logic [31:0] mask);
    return ($countones(v) == 1) && ((v & ~mask) == 32'd0);
  endfunction

  function automatic logic [31:0] lowest_page(input logic [31:0] mask);
    logic [31:0] r;
    r = 32'd0;
    for (int i = 31; i >= 0; i--) begin
      if (mask[i]) r = 32'd1 << i;
    end
    return r;
  endfunction

  function automatic logic [CNT_W-1:0] rid_first(input logic [CNT_W-1:0] nv, input logic ari,
                                                 input logic [CNT_W-1:0] ofs_std, input logic [CNT_W-1:0] ofs_ari,
                                                 input logic [CNT_W-1:0] split, input logic [CNT_W-1:0] bump);
    if (ari) return ofs_ari;
    return (nv > split) ? (ofs_std + bump) : ofs_std;
  endfunction

  function automatic logic [CNT_W-1:0] rid_stride(input logic ari, input logic [CNT_W-1:0] s_std,
                                                  input logic [CNT_W-1:0] s_ari);
    return ari ? s_ari : s_std;
  endfunction

endpackage

// File: rtl/svf_ctrl_regs.sv
module svf_ctrl_regs
  import svf_pkg::*;
#(
  parameter int unsigned INITIAL_VFS = 8,
  parameter int unsigned TOTAL_VFS   = 16,
  parameter bit          MIG_CAPABLE = 1'b1,
  parameter logic [31:0] SUPP_PAGES  = 32'h0000_0553
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flr,
  input  logic             wr_ctl,
  input  logic             wr_numvf,
  input  logic             wr_page,
  input  logic [31:0]      wdata,
  output ctl_t             ctl_q,
  output logic [CNT_W-1:0] numvf_q,
  output logic [31:0]      page_q,
  output logic             numvf_rej,
  output logic             page_rej
);

  localparam logic [CNT_W-1:0] INIT_C   = CNT_W'(INITIAL_VFS);
  localparam logic [CNT_W-1:0] TOT_C    = CNT_W'(TOTAL_VFS);
  localparam logic [31:0]      PAGE_DEF = lowest_page(SUPP_PAGES);

  logic numvf_ok;
  logic page_ok;

  assign numvf_ok  = !ctl_q.en && count_legal(wdata[CNT_W-1:0], ctl_q.mig, INIT_C, TOT_C);
  assign page_ok   = page_legal(wdata, SUPP_PAGES);
  assign numvf_rej = wr_numvf && !numvf_ok;
  assign page_rej  = wr_page && !page_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (flr) begin
      ctl_q.en  <= 1'b0;
      ctl_q.mig <= 1'b0;
      ctl_q.mse <= 1'b0;
    end else if (wr_ctl) begin
      ctl_q.en  <= wdata[0];
      ctl_q.mig <= wdata[1] & MIG_CAPABLE;
      ctl_q.ari <= wdata[2];
      ctl_q.mse <= wdata[3];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    numvf_q <= '0;
    else if (wr_numvf && numvf_ok) numvf_q <= wdata[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 page_q <= PAGE_DEF;
    else if (wr_page && page_ok) page_q <= wdata;
  end

endmodule

// File: rtl/svf_rid_layout.sv
module svf_rid_layout
  import svf_pkg::*;
#(
  parameter logic [CNT_W-1:0] OFS_STD = 16'd4,
  parameter logic [CNT_W-1:0] OFS_ARI = 16'd1,
  parameter logic [CNT_W-1:0] SPLIT   = 16'd8,
  parameter logic [CNT_W-1:0] BUMP    = 16'd8,
  parameter logic [CNT_W-1:0] STR_STD = 16'd2,
  parameter logic [CNT_W-1:0] STR_ARI = 16'd1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] numvf,
  input  logic             ari,
  output logic [CNT_W-1:0] first_q,
  output logic [CNT_W-1:0] stride_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q  <= rid_first('0, 1'b0, OFS_STD, OFS_ARI, SPLIT, BUMP);
      stride_q <= rid_stride(1'b0, STR_STD, STR_ARI);
    end else begin
      first_q  <= rid_first(numvf, ari, OFS_STD, OFS_ARI, SPLIT, BUMP);
      stride_q <= rid_stride(ari, STR_STD, STR_ARI);
    end
  end

endmodule

// File: rtl/svf_read_mux.sv
module svf_read_mux
  import svf_pkg::*;
#(
  parameter logic [15:0] CAP_ID      = 16'h0010,
  parameter logic [3:0]  CAP_VER     = 4'h1,
  parameter logic [11:0] NEXT_PTR    = 12'h140,
  parameter int unsigned INITIAL_VFS = 8,
  parameter int unsigned TOTAL_VFS   = 16,
  parameter bit          MIG_CAPABLE = 1'b1,
  parameter logic [31:0] SUPP_PAGES  = 32'h0000_0553
) (
  input  logic [ADDR_W-1:0] addr,
  input  ctl_t              ctl,
  input  logic [CNT_W-1:0]  numvf,
  input  logic [CNT_W-1:0]  first,
  input  logic [CNT_W-1:0]  stride,
  input  logic [31:0]       page,
  output logic [31:0]       rdata
);

  always_comb begin
    case (addr)
      IDX_HDR:   rdata = {NEXT_PTR, CAP_VER, CAP_ID};
      IDX_CAP:   rdata = {31'd0, MIG_CAPABLE};
      IDX_CTL:   rdata = {28'd0, ctl.mse, ctl.ari, ctl.mig, ctl.en};
      IDX_VFCNT: rdata = {CNT_W'(TOTAL_VFS), CNT_W'(INITIAL_VFS)};
      IDX_NUMVF: rdata = {16'd0, numvf};
      IDX_RID:   rdata = {stride, first};
      IDX_PGSUP: rdata = SUPP_PAGES;
      IDX_PGSEL: rdata = page;
      default:   rdata = 32'd0;
    endcase
  end

endmodule

// File: rtl/svf_cap_regs.sv
module svf_cap_regs
  import svf_pkg::*;
#(
  parameter logic [15:0] CAP_ID      = 16'h0010,
  parameter logic [3:0]  CAP_VER     = 4'h1,
  parameter logic [11:0] NEXT_PTR    = 12'h140,
  parameter int unsigned INITIAL_VFS = 8,
  parameter int unsigned TOTAL_VFS   = 16,
  parameter bit          MIG_CAPABLE = 1'b1,
  parameter logic [31:0] SUPP_PAGES  = 32'h0000_0553,
  parameter logic [15:0] OFS_STD     = 16'd4,
  parameter logic [15:0] OFS_ARI     = 16'd1,
  parameter logic [15:0] SPLIT       = 16'd8,
  parameter logic [15:0] BUMP        = 16'd8,
  parameter logic [15:0] STR_STD     = 16'd2,
  parameter logic [15:0] STR_ARI     = 16'd1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flr,
  input  logic        cfg_wr,
  input  logic [3:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output logic        vf_en_o,
  output logic        vf_mem_en_o,
  output logic [15:0] vf_count_o,
  output logic [31:0] page_size_o
);

  ctl_t             ctl_q;
  logic [CNT_W-1:0] numvf_q;
  logic [CNT_W-1:0] first_q;
  logic [CNT_W-1:0] stride_q;
  logic [31:0]      page_q;
  logic             numvf_rej;
  logic             page_rej;
  logic             wr_ctl;
  logic             wr_numvf;
  logic             wr_page;

  assign wr_ctl   = cfg_wr && (cfg_addr == IDX_CTL);
  assign wr_numvf = cfg_wr && (cfg_addr == IDX_NUMVF);
  assign wr_page  = cfg_wr && (cfg_addr == IDX_PGSEL);

  svf_ctrl_regs #(
    .INITIAL_VFS(INITIAL_VFS), .TOTAL_VFS(TOTAL_VFS),
    .MIG_CAPABLE(MIG_CAPABLE), .SUPP_PAGES(SUPP_PAGES)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .flr(flr),
    .wr_ctl(wr_ctl), .wr_numvf(wr_numvf), .wr_page(wr_page), .wdata(cfg_wdata),
    .ctl_q(ctl_q), .numvf_q(numvf_q), .page_q(page_q),
    .numvf_rej(numvf_rej), .page_rej(page_rej)
  );

  svf_rid_layout #(
    .OFS_STD(OFS_STD), .OFS_ARI(OFS_ARI), .SPLIT(SPLIT),
    .BUMP(BUMP), .STR_STD(STR_STD), .STR_ARI(STR_ARI)
  ) u_layout (
    .clk(clk), .rst_n(rst_n), .numvf(numvf_q), .ari(ctl_q.ari),
    .first_q(first_q), .stride_q(stride_q)
  );

  svf_read_mux #(
    .CAP_ID(CAP_ID), .CAP_VER(CAP_VER), .NEXT_PTR(NEXT_PTR),
    .INITIAL_VFS(INITIAL_VFS), .TOTAL_VFS(TOTAL_VFS),
    .MIG_CAPABLE(MIG_CAPABLE), .SUPP_PAGES(SUPP_PAGES)
  ) u_rmux (
    .addr(cfg_addr), .ctl(ctl_q), .numvf(numvf_q), .first(first_q),
    .stride(stride_q), .page(page_q), .rdata(cfg_rdata)
  );

  assign vf_en_o     = ctl_q.en;
  assign vf_mem_en_o = ctl_q.en & ctl_q.mse;
  assign vf_count_o  = ctl_q.en ? numvf_q : '0;
  assign page_size_o = page_q;

endmodule

// File: rtl/svf_cap_regs_chk.sv
module svf_cap_regs_chk #(
  parameter int unsigned TOTAL_VFS  = 16,
  parameter logic [31:0] SUPP_PAGES = 32'h0000_0553
) (
  input logic        clk,
  input logic        rst_n,
  input logic        flr,
  input logic        vf_en_o,
  input logic        vf_mem_en_o,
  input logic [15:0] vf_count_o,
  input logic [31:0] page_size_o,
  input logic [15:0] numvf_q,
  input logic        numvf_rej,
  input logic        page_rej
);

  localparam logic [15:0] TOT_C = 16'(TOTAL_VFS);

  p_count_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !vf_en_o |-> (vf_count_o == 16'd0));

  p_mem_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vf_mem_en_o |-> vf_en_o);

  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    numvf_q <= TOT_C);

  p_count_reject_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    numvf_rej |=> $stable(numvf_q));

  p_count_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (vf_en_o && $past(vf_en_o)) |-> $stable(numvf_q));

  p_page_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(page_size_o) == 1) && ((page_size_o & ~SUPP_PAGES) == 32'd0));

  p_page_reject_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    page_rej |=> $stable(page_size_o));

  p_flr_stops_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flr |=> (!vf_en_o && !vf_mem_en_o));

endmodule

bind svf_cap_regs svf_cap_regs_chk #(
  .TOTAL_VFS(TOTAL_VFS), .SUPP_PAGES(SUPP_PAGES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .flr(flr), .vf_en_o(vf_en_o), .vf_mem_en_o(vf_mem_en_o),
  .vf_count_o(vf_count_o), .page_size_o(page_size_o), .numvf_q(numvf_q),
  .numvf_rej(numvf_rej), .page_rej(page_rej)
);

// File: tb/svf_cap_regs_test.sv
`timescale 1ns/1ps
module svf_cap_regs_test;

  localparam int unsigned  T_INIT = 8;
  localparam int unsigned  T_TOT  = 16;
  localparam logic [31:0]  T_SUPP = 32'h0000_0553;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flr = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [3:0]  cfg_addr = 4'h0;
  logic [31:0] cfg_wdata = 32'd0;
  logic [31:0] cfg_rdata;
  logic        vf_en_o, vf_mem_en_o;
  logic [15:0] vf_count_o;
  logic [31:0] page_size_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  svf_cap_regs uut (
    .clk(clk), .rst_n(rst_n), .flr(flr), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .vf_en_o(vf_en_o),
    .vf_mem_en_o(vf_mem_en_o), .vf_count_o(vf_count_o), .page_size_o(page_size_o)
  );

  // reference state
  logic        m_en, m_mig, m_ari, m_mse;
  logic [15:0] m_nv, m_ofs, m_str;
  logic [31:0] m_pg;

  function automatic logic [15:0] ref_first(input logic [15:0] nv, input logic ari);
    if (ari) return 16'd1;
    if (nv > 16'd8) return 16'd12;
    return 16'd4;
  endfunction

  function automatic logic ref_count_ok(input logic [15:0] v, input logic mig);
    int lim;
    lim = mig ? T_TOT : T_INIT;
    return (int'(v) >= 1) && (int'(v) <= lim);
  endfunction

  function automatic logic ref_page_ok(input logic [31:0] v);
    int ones;
    ones = 0;
    for (int i = 0; i < 32; i++) if (v[i]) ones++;
    return (ones == 1) && ((v & T_SUPP) == v);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_mig = 0; m_ari = 0; m_mse = 0;
      m_nv = 0; m_pg = 32'd1; m_ofs = 16'd4; m_str = 16'd2;
    end else begin
      m_ofs = ref_first(m_nv, m_ari);
      m_str = m_ari ? 16'd1 : 16'd2;
      if (flr) begin
        m_en = 0; m_mig = 0; m_mse = 0;
      end else if (cfg_wr && cfg_addr == 4'h2) begin
        m_en = cfg_wdata[0]; m_mig = cfg_wdata[1]; m_ari = cfg_wdata[2]; m_mse = cfg_wdata[3];
      end
      if (cfg_wr && cfg_addr == 4'h4 && !m_en_prev() && ref_count_ok(cfg_wdata[15:0], m_mig_prev()))
        m_nv = cfg_wdata[15:0];
      if (cfg_wr && cfg_addr == 4'h7 && ref_page_ok(cfg_wdata))
        m_pg = cfg_wdata;
    end
  end

  // values of enable / migration before the current edge
  logic p_en, p_mig;
  always @(negedge clk) begin p_en = m_en; p_mig = m_mig; end
  function automatic logic m_en_prev();  return p_en;  endfunction
  function automatic logic m_mig_prev(); return p_mig; endfunction

  function automatic logic [31:0] ref_read(input int a);
    case (a)
      0: return 32'h1401_0010;
      1: return 32'd1;
      2: return {28'd0, m_mse, m_ari, m_mig, m_en};
      3: return {16'd16, 16'd8};
      4: return {16'd0, m_nv};
      5: return {m_str, m_ofs};
      6: return T_SUPP;
      7: return m_pg;
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input int a, input string tag);
    @(negedge clk);
    cfg_addr = 4'(a);
    #1;
    chk(tag, cfg_rdata, ref_read(a));
  endtask

  task automatic chk_outs(input string tag);
    @(negedge clk);
    #1;
    chk({tag, " vf_en_o R8"}, {31'd0, vf_en_o}, {31'd0, m_en});
    chk({tag, " vf_count_o R8"}, {16'd0, vf_count_o}, m_en ? {16'd0, m_nv} : 32'd0);
    chk({tag, " vf_mem_en_o R8"}, {31'd0, vf_mem_en_o}, {31'd0, m_en & m_mse});
    chk({tag, " page_size_o R5"}, page_size_o, m_pg);
  endtask

  task automatic chk_all(input string tag);
    for (int a = 0; a < 8; a++) rd(a, {tag, " readback R1/R2/R3/R5/R7"});
    rd(9, {tag, " unmapped R6"});
    chk_outs(tag);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic pulse_flr();
    @(negedge clk);
    flr = 1'b1;
    @(negedge clk);
    flr = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd7711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9: reset state
    chk_all("R9 reset");
    chk("R9 page default", page_size_o, 32'd1);
    chk("R1 header", ref_read(0), 32'h1401_0010);

    // R3: limits without migration
    wr(4'h4, 32'd0);  chk_outs("R3 zero");  rd(4, "R3 zero rejected");
    wr(4'h4, 32'd8);  rd(4, "R3 initial limit accepted");
    chk("R3 count 8", ref_read(4), 32'd8);
    wr(4'h4, 32'd9);  rd(4, "R3 above initial rejected");
    // R2/R3: migration raises the limit
    wr(4'h2, 32'h2);  rd(2, "R2 migration bit");
    wr(4'h4, 32'd16); rd(4, "R3 total limit accepted");
    chk("R3 count 16", ref_read(4), 32'd16);
    wr(4'h4, 32'd17); rd(4, "R3 above total rejected");
    // R7: one-cycle lag after a count change
    wr(4'h4, 32'd5);
    #1 cfg_addr = 4'h5; #1;
    chk("R7 lag old pair", cfg_rdata, {16'd2, 16'd12});
    @(negedge clk); #1;
    chk("R7 new pair", cfg_rdata, {16'd2, 16'd4});
    wr(4'h2, 32'h4);  @(negedge clk); rd(5, "R7 ari pair");
    chk("R7 ari value", ref_read(5), {16'd1, 16'd1});
    // R4: locked while enabled
    wr(4'h2, 32'h9);
    wr(4'h4, 32'd3);  rd(4, "R4 write while enabled ignored");
    chk_outs("R4/R8 enabled");
    chk("R8 count enabled", {16'd0, vf_count_o}, 32'd5);
    // R5: page legality
    wr(4'h7, 32'h0000_0010); rd(7, "R5 supported page accepted");
    wr(4'h7, 32'h0000_0004); rd(7, "R5 unsupported page rejected");
    wr(4'h7, 32'h0000_0011); rd(7, "R5 two bits rejected");
    wr(4'h7, 32'h0);         rd(7, "R5 zero rejected");
    chk("R5 page kept", page_size_o, 32'h10);
    // R6: read-only indices
    wr(4'h0, 32'hFFFF_FFFF); wr(4'h1, 32'h0); wr(4'h3, 32'h0);
    wr(4'h5, 32'h1234_5678); wr(4'h6, 32'hFFFF_FFFF); wr(4'h9, 32'hFFFF_FFFF);
    chk_all("R6 read-only");
    // R10: function-level reset
    wr(4'h2, 32'hB);
    pulse_flr();
    chk_all("R10 flr");
    chk("R10 count kept", ref_read(4), 32'd5);

    // random phase
    for (int it = 0; it < 400; it++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op <= 2)      wr(4'h2, {28'd0, 4'($urandom_range(0, 15)) & (($urandom_range(0, 2) == 0) ? 4'hF : 4'hE)});
      else if (op <= 5) wr(4'h4, 32'($urandom_range(0, 20)));
      else if (op <= 7) wr(4'h7, ($urandom_range(0, 3) == 0) ? $urandom() : (32'd1 << $urandom_range(0, 12)));
      else if (op == 8) wr(4'($urandom_range(0, 15)) | 4'h8, $urandom());
      else              pulse_flr();
      chk_outs("rand R3/R4/R5/R8/R10");
      if (it % 10 == 0) chk_all("rand R2/R7");
    end

    // R9: conventional reset mid-run
    wr(4'h2, 32'hF);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk_all("R9 re-reset");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule